// File: doc/BRIEF.md
# Method Queue Ring Buffer

This block is the holding queue between a command decoder, which produces method/data pairs, and a dispatcher, which consumes them in order. It keeps a parameterised number of entries (128 by default). Each entry is a 16-bit packed method word plus a 32-bit data word. The decoder writes one pair per cycle with a push strobe. The dispatcher takes the oldest pair with a pop strobe and receives it on registered outputs on the following cycle.

Both positions are kept as byte offsets that step by 4. They wrap inside the offset range, which is 0 to 508 for 128 entries. Both offsets are visible at the ports. Fullness is not derived from a count. It is held in two explicit flags: an empty mark and a full mark. Each side sets one of these flags when its own step meets the other offset, and clears the other flag when it moves.

Top module: `mq_ring`

## Requirements
- R1: After reset, both offsets are 0, the empty mark is 1, the full mark is 0 and the read-valid output is 0.
- R2: Each accepted push advances the write offset by 4, modulo the offset range (mask 0x1FC for 128 entries), so 508 is followed by 0.
- R3: Each accepted pop advances the read offset by 4 under the same wrap rule as the write offset.
- R4: A push alone whose new write offset equals the read offset sets the full mark. With 128 entries, this happens on the 128th push from empty.
- R5: An accepted push clears the empty mark.
- R6: A pop alone whose new read offset equals the write offset sets the empty mark. An accepted pop clears the full mark.
- R7: A push while the full mark is set is ignored: the write offset, the flags and the stored entries do not change. A pop while the empty mark is set is ignored: the read offset does not change and no read-valid pulse appears.
- R8: The stored method word is laid out as follows: the method type is in bit 0, bit 1 is 0, the 11-bit method address is in bits 12:2 and the subchannel is in bits 15:13.
- R9: Entries come out in the order they were pushed. The method word and the data word of an accepted pop appear, with read-valid high, on the cycle after the pop.
- R10: A push and a pop in the same cycle, with neither mark set, are both accepted. Both offsets advance and both marks stay clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Write strobe |
| push_type | input | 1 | Method type bit |
| push_mthd | input | 11 | Method address (word index) |
| push_subch | input | 3 | Subchannel |
| push_data | input | 32 | Data word |
| pop | input | 1 | Read strobe |
| rd_valid | output | 1 | Registered: a popped entry is on rd_word/rd_data |
| rd_word | output | 16 | Packed method word of the popped entry |
| rd_data | output | 32 | Data word of the popped entry |
| put_ofs | output | 9 | Write byte offset |
| get_ofs | output | 9 | Read byte offset |
| low_mark | output | 1 | Empty flag |
| high_mark | output | 1 | Full flag |

## Verification
Every result of this block is due exactly one rising edge after the strobe that causes it. This holds for the offsets and both marks after a push or pop. It also holds for the read-valid pulse with the popped method and data words. The bench applies each strobe at a falling edge and samples all outputs 1 ns after the next rising edge. It compares them against an occupancy model kept in the bench. Flag transitions, the wrap from 508 to 0, ignored strobes at both limits and simultaneous push and pop are each hit on a known cycle.

// File: rtl/mq_pkg.sv
package mq_pkg;
  localparam int MW_W = 16;
  localparam int DW_W = 32;
  localparam int MA_W = 11;
  localparam int SC_W = 3;

  typedef struct packed {
    logic [MW_W-1:0] mw;
    logic [DW_W-1:0] dw;
  } mq_entry_t;

  function automatic logic [MW_W-1:0] mq_pack(input logic typ,
                                               input logic [MA_W-1:0] mth,
                                               input logic [SC_W-1:0] sc);
    return {sc, mth, 1'b0, typ};
  endfunction
endpackage

// File: rtl/mq_offset.sv
module mq_offset #(
  parameter int OFS_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [OFS_W-1:0] ofs,
  output logic [OFS_W-1:0] ofs_nxt
);
  localparam logic [OFS_W-1:0] STEP = OFS_W'(4);

  // Adding 4 to a value whose two low bits are zero wraps naturally
  // at the top of the offset range, matching the mask rule.
  always_comb ofs_nxt = adv ? ofs + STEP : ofs;

  always_ff @(posedge clk) begin
    if (rst) ofs <= '0;
    else     ofs <= ofs_nxt;
  end

  a_r2_r3_step: assert property (@(posedge clk) disable iff (rst)
    adv |=> ofs == OFS_W'($past(ofs) + STEP));

  a_r2_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ofs));

  a_r2_r3_align: assert property (@(posedge clk) disable iff (rst)
    ofs[1:0] == 2'b00);
endmodule

// File: rtl/mq_store.sv
module mq_store
  import mq_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  mq_entry_t        wr_entry,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output mq_entry_t        rd_entry,
  output logic             rd_valid
);
  mq_entry_t mem [DEPTH];

  // Plain write port, no reset: suitable for block RAM inference.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_entry;
  end

  // Registered read port with enable.
  always_ff @(posedge clk) begin
    if (rd_en) rd_entry <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_en;
  end

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
endmodule

// File: rtl/mq_marks.sv
module mq_marks #(
  parameter int OFS_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_acc,
  input  logic             pop_acc,
  input  logic [OFS_W-1:0] put_nxt,
  input  logic [OFS_W-1:0] get_nxt,
  output logic             low_mark,
  output logic             high_mark
);
  logic meet;
  always_comb meet = (put_nxt == get_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_mark  <= 1'b1;
      high_mark <= 1'b0;
    end else begin
      if (push_acc && !pop_acc && meet)      high_mark <= 1'b1;
      else if (pop_acc)                      high_mark <= 1'b0;
      if (pop_acc && !push_acc && meet)      low_mark  <= 1'b1;
      else if (push_acc)                     low_mark  <= 1'b0;
    end
  end

  a_r5_low_clear: assert property (@(posedge clk) disable iff (rst)
    push_acc |=> !low_mark);

  a_r6_high_clear: assert property (@(posedge clk) disable iff (rst)
    pop_acc |=> !high_mark);

  a_r4_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(low_mark && high_mark));

  a_r10_both_clear: assert property (@(posedge clk) disable iff (rst)
    (push_acc && pop_acc) |=> (!low_mark && !high_mark));
endmodule

// File: rtl/mq_ring.sv
module mq_ring
  import mq_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OFS_W = IDX_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             push_type,
  input  logic [MA_W-1:0]  push_mthd,
  input  logic [SC_W-1:0]  push_subch,
  input  logic [DW_W-1:0]  push_data,
  input  logic             pop,
  output logic             rd_valid,
  output logic [MW_W-1:0]  rd_word,
  output logic [DW_W-1:0]  rd_data,
  output logic [OFS_W-1:0] put_ofs,
  output logic [OFS_W-1:0] get_ofs,
  output logic             low_mark,
  output logic             high_mark
);
  logic             push_acc, pop_acc;
  logic [OFS_W-1:0] put_nxt, get_nxt;
  mq_entry_t        wr_entry, rd_entry;

  always_comb begin
    push_acc    = push && !high_mark;
    pop_acc     = pop && !low_mark;
    wr_entry.mw = mq_pack(push_type, push_mthd, push_subch);
    wr_entry.dw = push_data;
    rd_word     = rd_entry.mw;
    rd_data     = rd_entry.dw;
  end

  mq_offset #(.OFS_W(OFS_W)) u_put (
    .clk(clk), .rst(rst), .adv(push_acc), .ofs(put_ofs), .ofs_nxt(put_nxt));

  mq_offset #(.OFS_W(OFS_W)) u_get (
    .clk(clk), .rst(rst), .adv(pop_acc), .ofs(get_ofs), .ofs_nxt(get_nxt));

  mq_marks #(.OFS_W(OFS_W)) u_marks (
    .clk(clk), .rst(rst), .push_acc(push_acc), .pop_acc(pop_acc),
    .put_nxt(put_nxt), .get_nxt(get_nxt),
    .low_mark(low_mark), .high_mark(high_mark));

  mq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(push_acc), .wr_idx(put_ofs[OFS_W-1:2]), .wr_entry(wr_entry),
    .rd_en(pop_acc), .rd_idx(get_ofs[OFS_W-1:2]),
    .rd_entry(rd_entry), .rd_valid(rd_valid));

  a_r7_full_push_ignored: assert property (@(posedge clk) disable iff (rst)
    (push && high_mark) |=> $stable(put_ofs));

  a_r7_empty_pop_ignored: assert property (@(posedge clk) disable iff (rst)
    (pop && low_mark) |=> (!rd_valid && $stable(get_ofs)));

  a_r4_full_meets: assert property (@(posedge clk) disable iff (rst)
    high_mark |-> put_ofs == get_ofs);

  a_r6_empty_meets: assert property (@(posedge clk) disable iff (rst)
    low_mark |-> put_ofs == get_ofs);

  a_r8_bit1_zero: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_word[1] == 1'b0);
endmodule

// File: tb/tb_mq_ring.sv
module tb_mq_ring;
  localparam int DEPTH = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push = 1'b0, push_type = 1'b0, pop = 1'b0;
  logic [10:0] push_mthd = '0;
  logic [2:0]  push_subch = '0;
  logic [31:0] push_data = '0;
  logic        rd_valid, low_mark, high_mark;
  logic [15:0] rd_word;
  logic [31:0] rd_data;
  logic [8:0]  put_ofs, get_ofs;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model
  logic [15:0] mq_w[$];
  logic [31:0] mq_d[$];
  int          e_put = 0, e_get = 0;

  always #5 clk = ~clk;

  mq_ring #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .push(push), .push_type(push_type),
    .push_mthd(push_mthd), .push_subch(push_subch), .push_data(push_data),
    .pop(pop), .rd_valid(rd_valid), .rd_word(rd_word), .rd_data(rd_data),
    .put_ofs(put_ofs), .get_ofs(get_ofs),
    .low_mark(low_mark), .high_mark(high_mark));

  task automatic chk(input string req, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, sample 1 ns after rising edge.
  task automatic step(input logic ps, input logic t, input logic [10:0] m,
                      input logic [2:0] s, input logic [31:0] d, input logic pp);
    bit          a_push, a_pop;
    logic [15:0] ew;
    logic [31:0] ed;
    @(negedge clk);
    push = ps; push_type = t; push_mthd = m; push_subch = s; push_data = d; pop = pp;
    a_push = ps && (mq_w.size() < DEPTH);
    a_pop  = pp && (mq_w.size() > 0);
    ew = '0; ed = '0;
    if (a_pop) begin ew = mq_w.pop_front(); ed = mq_d.pop_front(); end
    if (a_push) begin mq_w.push_back({s, m, 1'b0, t}); mq_d.push_back(d); end
    if (a_push) e_put = (e_put + 4) & 'h1FC;
    if (a_pop)  e_get = (e_get + 4) & 'h1FC;
    @(posedge clk); #1;
    push = 1'b0; pop = 1'b0;
    chk("R2", "put_ofs", 48'(put_ofs), 48'(e_put));
    chk("R3", "get_ofs", 48'(get_ofs), 48'(e_get));
    chk("R4", "high_mark", 48'(high_mark), 48'(mq_w.size() == DEPTH));
    chk("R6", "low_mark", 48'(low_mark), 48'(mq_w.size() == 0));
    chk("R9", "rd_valid", 48'(rd_valid), 48'(a_pop));
    if (a_pop && rd_valid) begin
      chk("R8", "rd_word", 48'(rd_word), 48'(ew));
      chk("R9", "rd_data", 48'(rd_data), 48'(ed));
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "put_ofs", 48'(put_ofs), 48'(0));
    chk("R1", "get_ofs", 48'(get_ofs), 48'(0));
    chk("R1", "low_mark", 48'(low_mark), 48'(1));
    chk("R1", "high_mark", 48'(high_mark), 48'(0));
    chk("R1", "rd_valid", 48'(rd_valid), 48'(0));
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_pack_r8;
    step(1, 1'b1, 11'h7FF, 3'd7, 32'hDEADBEEF, 0);
    chk("R5", "low cleared", 48'(low_mark), 48'(0));
    step(1, 1'b0, 11'h001, 3'd0, 32'h00000001, 0);
    step(1, 1'b1, 11'h040, 3'd5, 32'hA5A5A5A5, 0);
    step(0, 0, '0, '0, '0, 1);
    chk("R8", "all fields set", 48'(rd_word), 48'hFFFD);
    step(0, 0, '0, '0, '0, 1);
    chk("R8", "method addr 1", 48'(rd_word), 48'h0004);
    step(0, 0, '0, '0, '0, 1);
    chk("R8", "mixed fields", 48'(rd_word), 48'hA101);
    chk("R6", "low set on drain", 48'(low_mark), 48'(1));
  endtask

  task automatic t_empty_pop_r7;
    logic [8:0] g;
    g = get_ofs;
    step(0, 0, '0, '0, '0, 1);
    chk("R7", "get unchanged on empty pop", 48'(get_ofs), 48'(g));
    chk("R7", "no valid on empty pop", 48'(rd_valid), 48'(0));
  endtask

  task automatic t_fill_drain;
    for (int i = 0; i < DEPTH; i++)
      step(1, i[0], 11'(i * 3), 3'(i), 32'h1000_0000 + 32'(i), 0);
    chk("R4", "full after depth pushes", 48'(high_mark), 48'(1));
    chk("R2", "put met get", 48'(put_ofs), 48'(get_ofs));
    // extra push is ignored; its data must never come out
    step(1, 1'b1, 11'h555, 3'd2, 32'hBAD0BAD0, 0);
    chk("R7", "put unchanged on full push", 48'(put_ofs), 48'(e_put));
    step(0, 0, '0, '0, '0, 1);
    chk("R6", "high cleared by pop", 48'(high_mark), 48'(0));
    for (int i = 1; i < DEPTH; i++) begin
      step(0, 0, '0, '0, '0, 1);
      chk("R7", "no trace of ignored push", 48'(rd_data == 32'hBAD0BAD0), 48'(0));
    end
    chk("R6", "empty after drain", 48'(low_mark), 48'(1));
  endtask

  task automatic t_simul_r10;
    step(1, 0, 11'h010, 3'd1, 32'h11111111, 0);
    step(1, 1, 11'h020, 3'd2, 32'h22222222, 0);
    for (int i = 0; i < 200; i++) begin
      step(1, i[1], 11'(i), 3'(i + 1), 32'hC000_0000 + 32'(i), 1);
      chk("R10", "marks clear", 48'({low_mark, high_mark}), 48'(0));
    end
    while (mq_w.size() > 0) step(0, 0, '0, '0, '0, 1);
    chk("R3", "get wrapped into range", 48'(get_ofs[1:0]), 48'(0));
  endtask

  task automatic t_wrap;
    // walk offsets to 508 and beyond with paired push/pop
    while (e_put != 508) begin
      step(1, 0, 11'h3, 3'd3, 32'h5, 0);
      step(0, 0, '0, '0, '0, 1);
    end
    chk("R2", "put at top", 48'(put_ofs), 48'(508));
    step(1, 1, 11'h7, 3'd4, 32'h77, 0);
    chk("R2", "put wraps to 0", 48'(put_ofs), 48'(0));
    step(0, 0, '0, '0, '0, 1);
    chk("R3", "get wraps to 0", 48'(get_ofs), 48'(0));
  endtask

  initial begin
    t_reset();
    t_empty_pop_r7();
    t_pack_r8();
    t_fill_drain();
    t_simul_r10();
    t_wrap();
    t_empty_pop_r7();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule